// File: doc/BRIEF.md
# Opcode-Fetch Refresh Counter

This block keeps an 8-bit counter that advances once for every opcode fetch the processor core performs. A prefix byte is fetched like a one-byte instruction, so it raises the fetch strobe on its own cycle and is counted separately. Only the lower seven bits advance. They wrap from 127 to 0, and the top bit keeps whatever value was last written into it.

Software can write the whole register through a load port, and a load takes priority over a fetch in the same cycle. The current value is visible on a read port, where software can use it as a cheap source of changing numbers. The lower seven bits also drive a refresh address output for the memory refresh logic.

Top module: `refresh_counter`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it is released, `regValue` is 8'h00.
- R2: A cycle with `fetchStb`=1 and `loadEn`=0 adds one to `regValue[6:0]` on the next cycle.
- R3: The 7-bit count field wraps from 7'd127 to 7'd0 on an increment.
- R4: An increment never changes `regValue[7]`, and this includes the wrap from 127 to 0.
- R5: A cycle with `loadEn`=1 writes all eight bits of `loadData` into `regValue` on the next cycle, bit 7 included.
- R6: When `loadEn` and `fetchStb` are both 1 in the same cycle, the loaded value is kept and no increment is applied.
- R7: A cycle with neither `fetchStb` nor `loadEn` leaves `regValue` unchanged.
- R8: `refreshAddr` always equals `regValue[6:0]`.
- R9: Fetch strobes on consecutive cycles, for example a prefix followed by an opcode, each add one, so N back-to-back strobes add N modulo 128.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchStb | input | 1 | One cycle per opcode or prefix fetch |
| loadEn | input | 1 | Write enable for the whole register |
| loadData | input | 8 | Value written when `loadEn` is 1 |
| regValue | output | 8 | Current register value |
| refreshAddr | output | 7 | Refresh address, which is the 7-bit count field |

## Verification
The assertions check the single-cycle rules on every clock: an increment adds one modulo 128 and keeps bit 7, a load copies the data on the previous cycle, idle cycles hold the value, the refresh address follows the count field, and the control never asserts load and increment together. Some behaviour only shows up in the bench's scenarios. These are the exact wrap points with bit 7 set and with bit 7 clear, the value that results from a load that collides with a fetch, runs of back-to-back prefix-style fetches, and a reset taken in the middle of a run.

// File: rtl/refresh_counter_pkg.sv
package refresh_counter_pkg;
  parameter int unsigned REG_W = 8;
  localparam int unsigned CNT_W = REG_W - 1;

  typedef struct packed {
    logic doLoad;
    logic doInc;
  } ctrlStrobes_t;
endpackage

// File: rtl/refresh_counter_ctrl.sv
module refresh_counter_ctrl
  import refresh_counter_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         fetchStb,
  input  logic         loadEn,
  output ctrlStrobes_t strobes
);
  // Load has priority over a fetch arriving in the same cycle
  always_comb begin
    strobes.doLoad = loadEn;
    strobes.doInc  = fetchStb & ~loadEn;
  end

  // R6: never load and increment in the same cycle
  a_r6_single_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.doLoad, strobes.doInc}));

  // R6: a fetch that collides with a load is dropped
  a_r6_load_wins: assert property (@(posedge clk) disable iff (!rstN)
    (loadEn && fetchStb) |-> !strobes.doInc);
endmodule

// File: rtl/refresh_counter_dp.sv
module refresh_counter_dp
  import refresh_counter_pkg::*;
#(
  parameter int unsigned W = REG_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strobes,
  input  logic [W-1:0] loadData,
  output logic [W-1:0] regValue
);
  localparam int unsigned CW = W - 1;

  logic [CW-1:0] cntField;
  logic          topBit;
  logic [CW-1:0] cntNext;

  assign cntNext = cntField + CW'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntField <= '0;
      topBit   <= 1'b0;
    end else if (strobes.doLoad) begin
      cntField <= loadData[CW-1:0];
      topBit   <= loadData[W-1];
    end else if (strobes.doInc) begin
      cntField <= cntNext;
    end
  end

  assign regValue = {topBit, cntField};

  // R2 and R3: count field advances modulo 2**CW
  a_r2_increment: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doInc |=> regValue[CW-1:0] == CW'($past(regValue[CW-1:0]) + 1'b1));

  // R4: the top bit survives every increment
  a_r4_msb_kept: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doInc |=> regValue[W-1] == $past(regValue[W-1]));

  // R5: a load copies the full word
  a_r5_load_all: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doLoad |=> regValue == $past(loadData));

  // R7: no strobe means no change
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.doLoad && !strobes.doInc) |=> $stable(regValue));
endmodule

// File: rtl/refresh_counter.sv
module refresh_counter
  import refresh_counter_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             fetchStb,
  input  logic             loadEn,
  input  logic [REG_W-1:0] loadData,
  output logic [REG_W-1:0] regValue,
  output logic [CNT_W-1:0] refreshAddr
);
  ctrlStrobes_t strobes;

  refresh_counter_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .fetchStb (fetchStb),
    .loadEn   (loadEn),
    .strobes  (strobes)
  );

  refresh_counter_dp #(.W(REG_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .loadData (loadData),
    .regValue (regValue)
  );

  assign refreshAddr = regValue[CNT_W-1:0];

  // R8: refresh address tracks the count field at every edge
  a_r8_refresh_addr: assert property (@(posedge clk) disable iff (!rstN)
    refreshAddr == regValue[CNT_W-1:0]);

  // R1: value is zero on the first cycle out of reset
  a_r1_reset_zero: assert property (@(posedge clk)
    !rstN |=> (!rstN || regValue == '0));
endmodule

// File: tb/refresh_counter_tb_top.sv
module refresh_counter_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       fetchStb = 1'b0;
  logic       loadEn = 1'b0;
  logic [7:0] loadData = 8'h00;
  logic [7:0] regValue;
  logic [6:0] refreshAddr;

  int checks = 0;
  int errors = 0;
  logic [7:0] model = 8'h00;

  always #2 clk = ~clk;

  refresh_counter dut_i (
    .clk(clk), .rstN(rstN), .fetchStb(fetchStb), .loadEn(loadEn),
    .loadData(loadData), .regValue(regValue), .refreshAddr(refreshAddr)
  );

  function automatic logic [7:0] nextVal(logic [7:0] cur, logic f, logic l, logic [7:0] d);
    if (l) return d;
    if (f) return {cur[7], cur[6:0] + 7'd1};
    return cur;
  endfunction

  task automatic check(string req, logic [7:0] exp);
    checks++;
    if (regValue !== exp) begin
      errors++;
      $display("FAIL %s: regValue actual %h expected %h", req, regValue, exp);
    end
    checks++;
    if (refreshAddr !== exp[6:0]) begin
      errors++;
      $display("FAIL R8 (%s): refreshAddr actual %h expected %h", req, refreshAddr, exp[6:0]);
    end
  endtask

  task automatic step(logic f, logic l, logic [7:0] d, string req);
    @(negedge clk);
    fetchStb = f; loadEn = l; loadData = d;
    @(posedge clk);
    model = nextVal(model, f, l, d);
    #1;
    check(req, model);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; fetchStb = 1'b0; loadEn = 1'b0;
    #1;
    model = 8'h00;
    check("R1 during reset", 8'h00);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    check("R1 first cycle after reset", 8'h00);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    #1;
    check("R1 reset value", 8'h00);
    doReset();
    step(1, 0, 8'h00, "R2 single fetch");
    step(0, 0, 8'h00, "R7 idle hold");
    step(0, 0, 8'h00, "R7 idle hold again");
    step(0, 1, 8'hA5, "R5 load with bit7 set");
    step(0, 1, 8'h7F, "R3 load 127");
    step(1, 0, 8'h00, "R3 R4 wrap with bit7 clear");
    step(0, 1, 8'hFF, "R5 load all ones");
    step(1, 0, 8'h00, "R3 R4 wrap keeps bit7 set");
    step(1, 1, 8'h3C, "R6 load wins over fetch");
    step(0, 0, 8'h00, "R6 R7 no late increment");
    step(0, 1, 8'hFD, "R5 load near wrap");
    for (int i = 0; i < 5; i++) step(1, 0, 8'h00, "R9 back-to-back fetches");
    doReset();
    for (int i = 0; i < 300; i++) step(1, 0, 8'h00, "R9 long fetch run");
    for (int i = 0; i < 3000; i++) begin
      logic f, l;
      logic [7:0] d;
      f = ($urandom % 4) != 0;
      l = ($urandom % 8) == 0;
      d = 8'($urandom);
      step(f, l, d, "R2 R5 R6 R7 random mix");
    end
    doReset();
    step(1, 1, 8'h81, "R6 collision after reset");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule